// File: doc/BRIEF.md
# Double-Buffered PWM Compare Timer

This block is a 16-bit up-counter with two compare registers that together make a pulse-width-modulated waveform. The period register sets the count at which the counter wraps to zero. The duty register sets the count at which the output turns on. A set/reset flip-flop holds the output. It is cleared on the period match and set on the duty match, so the output is low from count 0 up to and including the duty value, and high for the rest of the period. The counter advances only on cycles where the selected tick input is high. One of eight tick inputs is chosen by the mode register.

Software writes the block over a small write-only register bus. Address 0 is the mode register, 1 the period register, 2 the duty register, 3 the period shadow prime and 4 the duty shadow prime. Writes to any other address are ignored.

In buffered mode the comparators look at shadow copies of the two compare registers. A shadow copy takes the newly written value only when the counter equals the old shadow value, so a running period is never shortened or stretched by a write. Because the shadows start at zero, a write of any value to a prime address copies the current compare register straight into its shadow before counting starts.

Top module: `pwm_dbl_timer`

## Requirements
- R1: With period register value A (legal range 1 to 0xFFFE) and a tick on every cycle, the counter runs 0..A and wraps to 0, giving a period of A+1 ticks.
- R2: With duty register value B (0 <= B < A), `pwm_out` is low for counts 0..B and high for A-B ticks of each period.
- R3: When mode bit 14 is 1 (buffered), writing the period register in the middle of a period leaves that period at its old length. The new length applies from the next period.
- R4: When mode bit 14 is 0 (direct), a period register write reaches the comparator on the next clock, so it changes the period that is already running.
- R5: A write to address 3 copies the period register into the period shadow, and a write to address 4 copies the duty register into the duty shadow. The write data is ignored. An unprimed period shadow of 0 makes the first period match happen on the first tick.
- R6: A mode write with bit 15 (enable) clear stops counting and clears the counter and `pwm_out` to 0 on the next clock. While the block is disabled, the counter holds and `irq` stays low.
- R7: Mode bits 2:0 select which bit of `tick_src` gates counting. A selected source that is always low freezes the timer.
- R8: `irq` pulses high for one cycle on each period match when mode bit 3 is set, and never pulses when mode bit 3 is clear.
- R9: Mode bits 13:12 (direction) and the other reserved bits have no effect: the counter always counts up.
- R10: After reset, `pwm_out` and `irq` are 0 and all registers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_src | input | 8 | Candidate count-enable ticks, one picked by mode bits 2:0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 mode, 1 period, 2 duty, 3/4 shadow prime) |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Set/reset flip-flop output |
| irq | output | 1 | One-cycle pulse on period match |

## Verification
The main function is swept over every legal pair of small period and duty values, in both direct and buffered mode, with a tick on every cycle. This shows whether the period comes from A+1 and whether the high time comes from A-B, and shows that each mode picks the correct compare source. A period write made just after a rising edge tells the two modes apart, because only direct mode changes the running period. A half-rate tick and an always-low tick show that the source is selected and that counting is gated. Counting edges from enable to the first interrupt, once unprimed and once primed with a different period, shows whether a prime write reaches the shadow.

// File: rtl/pwm_dbl_timer.sv
module pwm_dbl_timer #(
  parameter int W    = 16,
  parameter int NSRC = 8,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic          pwm_out,
  output logic          irq
);
  localparam int SW = $clog2(NSRC);
  localparam logic [AW-1:0] A_MODE = AW'(0);
  localparam logic [AW-1:0] A_PER  = AW'(1);
  localparam logic [AW-1:0] A_DUTY = AW'(2);
  localparam logic [AW-1:0] A_PPER = AW'(3);
  localparam logic [AW-1:0] A_PDUT = AW'(4);

  logic [15:0]  mode;
  logic [W-1:0] per_q, duty_q, per_sh, duty_sh, cnt;
  logic         ff_q, irq_q;

  wire run    = mode[15];
  wire buffed = mode[14];
  wire ie     = mode[3];
  wire [SW-1:0] sel = mode[SW-1:0];
  wire step   = run & tick_src[sel];

  wire [W-1:0] cmp_per  = buffed ? per_sh  : per_q;
  wire [W-1:0] cmp_duty = buffed ? duty_sh : duty_q;
  wire hit_per  = (cnt == cmp_per);
  wire hit_duty = (cnt == cmp_duty);

  wire wr_mode = wr_en && (wr_addr == A_MODE);
  wire stop    = wr_mode && !wr_data[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= '0;
      per_q   <= '0;
      duty_q  <= '0;
      per_sh  <= '0;
      duty_sh <= '0;
      cnt     <= '0;
      ff_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_mode) mode <= wr_data[15:0];
      if (wr_en && wr_addr == A_PER)  per_q  <= wr_data;
      if (wr_en && wr_addr == A_DUTY) duty_q <= wr_data;

      if (wr_en && wr_addr == A_PPER) per_sh <= per_q;
      else if (step && buffed && cnt == per_sh) per_sh <= per_q;

      if (wr_en && wr_addr == A_PDUT) duty_sh <= duty_q;
      else if (step && buffed && cnt == duty_sh) duty_sh <= duty_q;

      if (stop) begin
        cnt  <= '0;
        ff_q <= 1'b0;
      end else if (step) begin
        if (hit_per) begin
          cnt   <= '0;
          ff_q  <= 1'b0;
          irq_q <= ie;
        end else begin
          cnt <= cnt + 1'b1;
          if (hit_duty) ff_q <= 1'b1;
        end
      end
    end
  end

  assign pwm_out = ff_q;
  assign irq     = irq_q;
endmodule

module pwm_dbl_timer_chk #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [W-1:0]  wr_data,
  input logic          pwm_out,
  input logic          irq,
  input logic          ie,
  input logic          run,
  input logic [W-1:0]  cnt
);
  // R6
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == '0 && !wr_data[15]) |=> (!pwm_out && cnt == '0));
  // R6
  halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(cnt));
  // R6
  irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(run));
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ie));
  // R1
  irq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0 && !pwm_out));
endmodule

bind pwm_dbl_timer pwm_dbl_timer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq),
  .ie(mode[3]), .run(mode[15]), .cnt(cnt)
);

// File: tb/pwm_dbl_timer_bench.sv
module pwm_dbl_timer_bench;
  localparam logic [15:0] EN = 16'h8000, BUF = 16'h4000, IE = 16'h0008;

  logic clk = 0, rst_n = 0, tgl = 0;
  logic wr_en = 0;
  logic [2:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic pwm_out, irq;
  wire [7:0] tick_src = {6'b0, tgl, 1'b1};

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) tgl <= ~tgl;

  pwm_dbl_timer u_pwm_dbl_timer (
    .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq));

  task automatic chk(input int act, input int exp, input string tag);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic to_rise(output int n);
    logic prev;
    prev = pwm_out; n = 0;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1; n++;
      if (pwm_out && !prev) return;
      prev = pwm_out;
    end
    n = -1;
  endtask

  task automatic measure(output int per, output int hi);
    logic prev;
    prev = 1; per = 0; hi = 1;
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1; per++;
      if (pwm_out && !prev) return;
      if (pwm_out) hi++;
      prev = pwm_out;
    end
    per = -1;
  endtask

  task automatic setup(input int a, input int b, input logic [15:0] md);
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'(a));
    wr(3'd2, 16'(b));
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd0, md);
  endtask

  task automatic edges_to_irq(output int n);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1; n++;
      if (irq) return;
    end
    n = -1;
  endtask

  task automatic run_all;
    int per, hi, n, cnt_irq;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk(pwm_out, 0, "R10 pwm after reset");
    chk(irq, 0, "R10 irq after reset");
    rst_n = 1;

    // R5 unprimed shadow: first match on first tick
    wr(3'd1, 16'd4); wr(3'd2, 16'd1);
    wr(3'd0, EN | BUF | IE);
    edges_to_irq(n);
    chk(n, 1, "R5 unprimed first match");
    // R5 primed shadow with data ignored
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd6);
    wr(3'd3, 16'h0002);
    wr(3'd4, 16'h0002);
    wr(3'd0, EN | BUF | IE);
    edges_to_irq(n);
    chk(n, 7, "R5 primed first match");

    // R1 R2 sweep both modes
    for (int m = 0; m < 2; m++)
      for (int a = 1; a <= 7; a++)
        for (int b = 0; b < a; b++) begin
          setup(a, b, m ? (EN | BUF | IE) : (EN | IE));
          to_rise(n);
          measure(per, hi);
          chk(per, a + 1, $sformatf("R1 period a=%0d b=%0d m=%0d", a, b, m));
          chk(hi, a - b, $sformatf("R2 high a=%0d b=%0d m=%0d", a, b, m));
        end

    // R4 direct mode: mid-period write shortens the running period
    setup(9, 1, EN);
    to_rise(n);
    wr(3'd1, 16'd7);
    to_rise(n);
    chk(n + 1, 8, "R4 direct mid-period write");

    // R3 buffered mode: running period unchanged, next one new
    setup(9, 1, EN | BUF);
    to_rise(n);
    wr(3'd1, 16'd7);
    to_rise(n);
    chk(n + 1, 10, "R3 buffered current period");
    measure(per, hi);
    chk(per, 8, "R3 buffered next period");

    // R8 irq count with and without enable bit
    setup(4, 1, EN | IE);
    to_rise(n);
    cnt_irq = 0;
    for (int i = 0; i < 15; i++) begin @(posedge clk); #1; if (irq) cnt_irq++; end
    chk(cnt_irq, 3, "R8 irq pulses per period");
    setup(4, 1, EN);
    cnt_irq = 0;
    for (int i = 0; i < 30; i++) begin @(posedge clk); #1; if (irq) cnt_irq++; end
    chk(cnt_irq, 0, "R8 irq masked");

    // R7 half-rate tick source and frozen source
    setup(3, 1, EN | IE | 16'h0001);
    to_rise(n);
    measure(per, hi);
    chk(per, 8, "R7 half-rate period");
    chk(hi, 4, "R7 half-rate high");
    setup(3, 1, EN | IE | 16'h0007);
    cnt_irq = 0; hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1; if (irq) cnt_irq++; if (pwm_out) hi++;
    end
    chk(cnt_irq + hi, 0, "R7 frozen source");

    // R9 direction and reserved bits ignored
    setup(5, 2, EN | IE | 16'h3070);
    to_rise(n);
    measure(per, hi);
    chk(per, 6, "R9 period with reserved bits");
    chk(hi, 3, "R9 high with reserved bits");

    // R6 disable clears output and freezes
    setup(6, 1, EN | IE);
    to_rise(n);
    chk(pwm_out, 1, "R6 output high before stop");
    wr(3'd0, 16'h0000);
    chk(pwm_out, 0, "R6 output cleared by stop");
    cnt_irq = 0; hi = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); #1; if (irq) cnt_irq++; if (pwm_out) hi++;
    end
    chk(cnt_irq + hi, 0, "R6 idle while disabled");
    // R6 counter restarts from zero: first rise after B+1 ticks
    wr(3'd0, EN);
    to_rise(n);
    chk(n, 2, "R6 restart from zero");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule